// File: doc/BRIEF.md
# Functional-Unit Scoreboard Issue Controller

This block decides when decoded instructions may enter, read and leave a set of ten independent functional units. One instruction per cycle is offered with a unit type, an optional destination register and up to two optional source registers. The controller assigns it to a free unit of that type, records which unit will produce the destination, and then lets each unit read its operands and write its result as soon as the register hazards allow. The arithmetic itself is not modelled; each unit is a fixed-latency countdown.

Hazards fall into three classes that stall different steps. A busy unit or a destination with an outstanding write holds the instruction at issue. A source that an earlier instruction has yet to produce holds only the operand read of the issued instruction. A destination that an older, still-unread instruction needs in its old form holds only the write-back of the finished unit. Other instructions keep flowing past each of these holds.

Registers are named by a 5-bit code `{class[1:0], index[2:0]}` over three classes of eight: class 0 operand, class 1 address, class 2 index. Code 16 (index register 0) is a constant zero.

Top module: `fu_scoreboard`

## Requirements
- R1: `issue_fire` is high only in a cycle where `in_valid` is high, and the offered instruction is accepted at that clock edge; `issue_stall` equals `in_valid` and not `issue_fire`; at most one instruction is accepted per cycle.
- R2: Type codes are 0 branch, 1 boolean, 2 shift, 3 float add, 4 long add, 5 divide, 6 multiply, 7 increment; units 0 to 5 carry types 0 to 5, units 6 and 7 multiply, units 8 and 9 increment; `issue_unit` names the lowest-numbered free unit of the requested type.
- R3: A unit is busy from its issue edge through the cycle of its write-back grant; an instruction whose type has no free unit is stalled.
- R4: An instruction whose enabled destination has a write outstanding from an earlier instruction is stalled until the cycle after that write-back.
- R5: A unit asserts `rd_go` once, in the first cycle after issue in which every enabled source has no outstanding producer; a producer granted write-back in cycle t releases its consumers for cycle t+1, including a consumer issued in cycle t.
- R6: A unit whose destination is register d is not granted write-back while an older issued unit that has d as an enabled source has not yet completed its `rd_go` cycle; the grant comes at the earliest in the cycle after that read.
- R7: Latencies are branch 1, boolean 3, shift 3, float add 4, long add 3, divide 29, multiply 10, increment 3; a unit becomes ready to write back LAT+1 cycles after its `rd_go`, so an unhindered instruction is granted LAT+2 cycles after its issue cycle.
- R8: At most one `wb_en` bit is high per cycle; among the ready units not held by R6 the one issued earliest is granted, and the rest retry on later cycles; `wb_dst` of the granted unit carries its destination code.
- R9: A destination of code 16 is discarded: it causes no R4 stall, `wb_wr` stays low at that unit's grant, and a source of code 16 never waits; `wb_wr` is high only with `wb_en` and an enabled destination.
- R10: After reset all units are free, no register has a pending write, `rd_go`, `wb_en` and `wb_wr` are zero, and the first valid instruction issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered this cycle |
| in_type | input | 3 | Functional unit type code |
| in_dst | input | 5 | Destination register code |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_src1 | input | 5 | First source register code |
| in_src1_en | input | 1 | First source used |
| in_src2 | input | 5 | Second source register code |
| in_src2_en | input | 1 | Second source used |
| issue_fire | output | 1 | Instruction accepted at this edge |
| issue_stall | output | 1 | Instruction offered but held |
| issue_unit | output | 4 | Unit receiving the accepted instruction |
| rd_go | output | 10 | Per-unit operand read this cycle |
| wb_en | output | 10 | Per-unit write-back grant this cycle |
| wb_wr | output | 10 | Per-unit register write this cycle |
| wb_dst | output | 50 | Per-unit destination code, 5 bits per unit, unit 0 lowest |

## Verification
The hardest state to reach is a write-back held by an older reader: a long producer must keep an older consumer waiting in its read step while a younger, short instruction targets one of that consumer's sources and finishes first. A directed sequence builds exactly this with a divide feeding a long add whose other source is overwritten by a quick boolean, and random traffic with a short register pool and slow divides recreates it repeatedly. A bench model built from the requirements predicts issue, read and grant cycles each cycle, so any premature release or wrong age order shows up at once.

// File: rtl/sb_pkg.sv
// Shared constants, unit map and command type for the scoreboard.
// Assumes ten units and a 5-bit register code {class, index}.
package sb_pkg;
    localparam int NUM_UNITS = 10;
    localparam int UID_W     = $clog2(NUM_UNITS);
    localparam int TYPE_W    = 3;
    localparam int CLS_W     = 2;
    localparam int IDX_W     = 3;
    localparam int REG_W     = CLS_W + IDX_W;
    localparam int NUM_REGS  = 1 << REG_W;
    localparam logic [REG_W-1:0] ZERO_REG = {2'd2, 3'd0};

    localparam int LAT_BRANCH = 1;
    localparam int LAT_BOOL   = 3;
    localparam int LAT_SHIFT  = 3;
    localparam int LAT_FADD   = 4;
    localparam int LAT_LADD   = 3;
    localparam int LAT_DIV    = 29;
    localparam int LAT_MUL    = 10;
    localparam int LAT_INC    = 3;
    localparam int CNT_W      = $clog2(LAT_DIV + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EXEC, ST_WB} slot_state_e;

    typedef struct packed {
        logic [REG_W-1:0]     dst;
        logic                 dst_en;
        logic [REG_W-1:0]     s1;
        logic                 s1_en;
        logic [NUM_UNITS-1:0] q1;
        logic [REG_W-1:0]     s2;
        logic                 s2_en;
        logic [NUM_UNITS-1:0] q2;
    } slot_cmd_t;

    // Type code carried by unit u; duplicates sit at the top.
    function automatic logic [TYPE_W-1:0] kind_of(int u);
        if (u < 6)      return TYPE_W'(u);
        else if (u < 8) return 3'd6;
        else            return 3'd7;
    endfunction

    // Fixed latency of a type code.
    function automatic int lat_of(logic [TYPE_W-1:0] k);
        case (k)
            3'd0:    return LAT_BRANCH;
            3'd1:    return LAT_BOOL;
            3'd2:    return LAT_SHIFT;
            3'd3:    return LAT_FADD;
            3'd4:    return LAT_LADD;
            3'd5:    return LAT_DIV;
            3'd6:    return LAT_MUL;
            default: return LAT_INC;
        endcase
    endfunction
endpackage

// File: rtl/sb_issue_pick.sv
// Picks the lowest-numbered free unit of the requested type.
// Assumes idle_i is high for units in the idle state only.
module sb_issue_pick
    import sb_pkg::*;
(
    input  logic [TYPE_W-1:0]    kind_i,
    input  logic [NUM_UNITS-1:0] idle_i,
    output logic                 hit_o,
    output logic [UID_W-1:0]     unit_o
);
    // Downward scan so the lowest matching unit is the last assignment.
    always_comb begin
        hit_o  = 1'b0;
        unit_o = '0;
        for (int u = NUM_UNITS - 1; u >= 0; u--) begin
            if (idle_i[u] && (kind_of(u) == kind_i)) begin
                hit_o  = 1'b1;
                unit_o = UID_W'(u);
            end
        end
    end
endmodule

// File: rtl/sb_unit_slot.sv
// One functional-unit slot: waits for operands, counts its latency,
// then holds the result until granted write-back.
// Assumes LAT >= 1 and that take_i only arrives while idle.
module sb_unit_slot
    import sb_pkg::*;
#(
    parameter int LAT = 1,
    parameter int UID = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_i,
    input  slot_cmd_t            cmd_i,
    input  logic [NUM_UNITS-1:0] grant_i,
    output logic                 idle_o,
    output logic                 reading_o,
    output logic                 rd_go_o,
    output logic                 ready_o,
    output logic [REG_W-1:0]     dst_o,
    output logic                 dst_en_o,
    output logic                 s1_live_o,
    output logic [REG_W-1:0]     s1_o,
    output logic                 s2_live_o,
    output logic [REG_W-1:0]     s2_o
);
    slot_state_e          st_q;
    logic [CNT_W-1:0]     cnt_q;
    slot_cmd_t            cmd_q;
    logic [NUM_UNITS-1:0] q1_q, q2_q;

    assign idle_o    = (st_q == ST_IDLE);
    assign reading_o = (st_q == ST_READ);
    assign ready_o   = (st_q == ST_WB);
    assign rd_go_o   = reading_o && (q1_q == '0) && (q2_q == '0);
    assign dst_o     = cmd_q.dst;
    assign dst_en_o  = cmd_q.dst_en;
    assign s1_live_o = reading_o && cmd_q.s1_en;
    assign s2_live_o = reading_o && cmd_q.s2_en;
    assign s1_o      = cmd_q.s1;
    assign s2_o      = cmd_q.s2;

    // Slot life cycle: idle -> read -> execute -> write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            cmd_q <= '0;
            q1_q  <= '0;
            q2_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (take_i) begin
                    st_q  <= ST_READ;
                    cmd_q <= cmd_i;
                    q1_q  <= cmd_i.q1;
                    q2_q  <= cmd_i.q2;
                end
                ST_READ: begin
                    q1_q <= q1_q & ~grant_i;
                    q2_q <= q2_q & ~grant_i;
                    if (rd_go_o) begin
                        st_q  <= ST_EXEC;
                        cnt_q <= CNT_W'(LAT);
                    end
                end
                ST_EXEC: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) st_q <= ST_WB;
                end
                default: if (grant_i[UID]) st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
// Write-back control: holds results that an older unread source still
// needs, then grants the oldest remaining ready unit.
// Assumes take_i is one-hot or zero and busy_i is the non-idle set.
module sb_wb_arbiter
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] take_i,
    input  logic [NUM_UNITS-1:0] busy_i,
    input  logic [NUM_UNITS-1:0] ready_i,
    input  logic [NUM_UNITS-1:0] reading_i,
    input  logic [NUM_UNITS-1:0] dst_en_i,
    input  logic [REG_W-1:0]     dst_i     [NUM_UNITS],
    input  logic [NUM_UNITS-1:0] s1_live_i,
    input  logic [REG_W-1:0]     s1_i      [NUM_UNITS],
    input  logic [NUM_UNITS-1:0] s2_live_i,
    input  logic [REG_W-1:0]     s2_i      [NUM_UNITS],
    output logic [NUM_UNITS-1:0] grant_o
);
    logic [NUM_UNITS-1:0] older_q [NUM_UNITS];   // older_q[v][u]: v issued before u
    logic [NUM_UNITS-1:0] hold, cand;

    // Age matrix: a new unit is younger than every unit busy at its issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_UNITS; v++) older_q[v] <= '0;
        end else begin
            for (int n = 0; n < NUM_UNITS; n++) begin
                if (take_i[n]) begin
                    for (int v = 0; v < NUM_UNITS; v++) begin
                        older_q[v][n] <= busy_i[v];
                        older_q[n][v] <= 1'b0;
                    end
                end
            end
        end
    end

    // Write-after-read hold: an older unit still waiting to read our target.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            hold[u] = 1'b0;
            for (int v = 0; v < NUM_UNITS; v++) begin
                if (dst_en_i[u] && older_q[v][u] && reading_i[v] &&
                    ((s1_live_i[v] && (s1_i[v] == dst_i[u])) ||
                     (s2_live_i[v] && (s2_i[v] == dst_i[u]))))
                    hold[u] = 1'b1;
            end
        end
        cand = ready_i & ~hold;
    end

    // Oldest-first grant among candidates.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            grant_o[u] = cand[u];
            for (int v = 0; v < NUM_UNITS; v++)
                if (cand[v] && older_q[v][u]) grant_o[u] = 1'b0;
        end
    end
endmodule

// File: rtl/fu_scoreboard.sv
// Scoreboard issue controller for ten fixed-latency functional units.
// Keeps the pending-write table, forms issue decisions and wires the
// unit slots to the write-back arbiter. Register code 16 is constant zero.
module fu_scoreboard
    import sb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [TYPE_W-1:0]            in_type,
    input  logic [REG_W-1:0]             in_dst,
    input  logic                         in_dst_en,
    input  logic [REG_W-1:0]             in_src1,
    input  logic                         in_src1_en,
    input  logic [REG_W-1:0]             in_src2,
    input  logic                         in_src2_en,
    output logic                         issue_fire,
    output logic                         issue_stall,
    output logic [UID_W-1:0]             issue_unit,
    output logic [NUM_UNITS-1:0]         rd_go,
    output logic [NUM_UNITS-1:0]         wb_en,
    output logic [NUM_UNITS-1:0]         wb_wr,
    output logic [NUM_UNITS*REG_W-1:0]   wb_dst
);
    logic                 pend_v  [NUM_REGS];
    logic [NUM_UNITS-1:0] pend_oh [NUM_REGS];

    logic [NUM_UNITS-1:0] idle, reading, ready, dst_en, s1_live, s2_live, take, grant;
    logic [REG_W-1:0]     dst [NUM_UNITS];
    logic [REG_W-1:0]     s1  [NUM_UNITS];
    logic [REG_W-1:0]     s2  [NUM_UNITS];
    logic                 hit, dst_keep;
    logic [UID_W-1:0]     pick;
    slot_cmd_t            cmd;

    sb_issue_pick u_pick (.kind_i(in_type), .idle_i(idle), .hit_o(hit), .unit_o(pick));

    // Issue decision and the command handed to the chosen slot.
    always_comb begin
        dst_keep    = in_dst_en && (in_dst != ZERO_REG);
        issue_fire  = in_valid && hit && !(dst_keep && pend_v[in_dst]);
        issue_stall = in_valid && !issue_fire;
        issue_unit  = pick;
        take        = issue_fire ? (NUM_UNITS'(1) << pick) : '0;
        cmd.dst     = in_dst;
        cmd.dst_en  = dst_keep;
        cmd.s1      = in_src1;
        cmd.s1_en   = in_src1_en;
        cmd.q1      = (in_src1_en && pend_v[in_src1]) ? (pend_oh[in_src1] & ~grant) : '0;
        cmd.s2      = in_src2;
        cmd.s2_en   = in_src2_en;
        cmd.q2      = (in_src2_en && pend_v[in_src2]) ? (pend_oh[in_src2] & ~grant) : '0;
    end

    // Pending-write table: set at issue, cleared at the producer's grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                pend_v[r]  <= 1'b0;
                pend_oh[r] <= '0;
            end
        end else begin
            for (int u = 0; u < NUM_UNITS; u++)
                if (grant[u] && dst_en[u]) pend_v[dst[u]] <= 1'b0;
            if (issue_fire && dst_keep) begin
                pend_v[in_dst]  <= 1'b1;
                pend_oh[in_dst] <= take;
            end
        end
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        sb_unit_slot #(.LAT(lat_of(kind_of(g))), .UID(g)) u_slot (
            .clk(clk), .rst_n(rst_n), .take_i(take[g]), .cmd_i(cmd), .grant_i(grant),
            .idle_o(idle[g]), .reading_o(reading[g]), .rd_go_o(rd_go[g]),
            .ready_o(ready[g]), .dst_o(dst[g]), .dst_en_o(dst_en[g]),
            .s1_live_o(s1_live[g]), .s1_o(s1[g]), .s2_live_o(s2_live[g]), .s2_o(s2[g])
        );
        assign wb_dst[g*REG_W +: REG_W] = dst[g];
    end

    sb_wb_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .take_i(take), .busy_i(~idle), .ready_i(ready),
        .reading_i(reading), .dst_en_i(dst_en), .dst_i(dst),
        .s1_live_i(s1_live), .s1_i(s1), .s2_live_i(s2_live), .s2_i(s2),
        .grant_o(grant)
    );

    assign wb_en = grant;
    assign wb_wr = grant & dst_en;
endmodule

// File: rtl/fu_scoreboard_chk.sv
// Port-level protocol checks for the scoreboard, bound to its top.
// Tracks unit occupancy from issue and grant pulses only.
module fu_scoreboard_chk
    import sb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 issue_fire,
    input logic                 issue_stall,
    input logic [UID_W-1:0]     issue_unit,
    input logic [NUM_UNITS-1:0] rd_go,
    input logic [NUM_UNITS-1:0] wb_en,
    input logic [NUM_UNITS-1:0] wb_wr
);
    logic [NUM_UNITS-1:0] occ_q, read_q;

    // Occupancy and read-done flags as seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            read_q <= '0;
        end else begin
            occ_q  <= (occ_q & ~wb_en) | (issue_fire ? (NUM_UNITS'(1) << issue_unit) : '0);
            read_q <= (read_q | rd_go) & ~wb_en;
        end
    end

    p_stall_def_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> (in_valid && !issue_fire));
    p_fire_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> in_valid);
    p_free_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> ((int'(issue_unit) < NUM_UNITS) && !occ_q[issue_unit]));
    p_grant_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en & ~occ_q) == '0);
    p_read_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go & ~occ_q) == '0);
    p_read_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go & read_q) == '0);
    p_grant_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en & ~read_q) == '0);
    p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_en));
    p_write_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wr & ~wb_en) == '0);
endmodule

bind fu_scoreboard fu_scoreboard_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .issue_fire(issue_fire),
    .issue_stall(issue_stall), .issue_unit(issue_unit), .rd_go(rd_go),
    .wb_en(wb_en), .wb_wr(wb_wr)
);

// File: tb/fu_scoreboard_tb_top.sv
module fu_scoreboard_tb_top;
    localparam int N = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_type = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       in_dst_en = 1'b0, in_src1_en = 1'b0, in_src2_en = 1'b0;
    logic       issue_fire, issue_stall;
    logic [3:0] issue_unit;
    logic [9:0] rd_go, wb_en, wb_wr;
    logic [49:0] wb_dst;

    fu_scoreboard dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src1(in_src1), .in_src1_en(in_src1_en),
        .in_src2(in_src2), .in_src2_en(in_src2_en), .issue_fire(issue_fire),
        .issue_stall(issue_stall), .issue_unit(issue_unit), .rd_go(rd_go),
        .wb_en(wb_en), .wb_wr(wb_wr), .wb_dst(wb_dst)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_bad = 0, cyc = 0, seqn = 0;
    bit finished = 0;

    // Requirement-level model state
    bit       b_busy [N];
    int       b_seq [N], b_dst [N], b_s1 [N], b_s2 [N], b_rdc [N];
    bit       b_dst_en [N], b_s1en [N], b_s2en [N], b_rd [N];
    bit [9:0] b_p1 [N], b_p2 [N];
    bit       pend [32];
    int       pend_u [32];
    bit       last_fire;
    bit [9:0] last_wb;

    function automatic int kind_of_u(int u);
        return (u < 6) ? u : ((u < 8) ? 6 : 7);
    endfunction

    function automatic int lat_k(int k);
        case (k)
            0: return 1;  1: return 3;  2: return 3;  3: return 4;
            4: return 3;  5: return 29; 6: return 10; default: return 3;
        endcase
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One cycle: sample before the edge, compare, advance the model.
    task automatic step();
        int       eu, gu, k;
        bit       dkeep, efire, war;
        bit [9:0] erd, elig, eg, ewr, p1, p2;
        string    tag;
        #8;
        eu = -1;
        for (int u = 0; u < N; u++)
            if (!b_busy[u] && kind_of_u(u) == int'(in_type) && eu < 0) eu = u;
        dkeep = in_dst_en && (in_dst != 5'd16);
        efire = in_valid && (eu >= 0) && !(dkeep && pend[in_dst]);
        if (in_valid && eu < 0) tag = "R3";
        else if (in_valid && dkeep && pend[in_dst]) tag = "R4";
        else tag = "R1";
        check(issue_fire == efire, tag, issue_fire, efire);
        check(issue_stall == (in_valid && !efire), tag, issue_stall, in_valid && !efire);
        if (efire && issue_fire) check(int'(issue_unit) == eu, "R2", issue_unit, eu);

        erd = '0;
        for (int u = 0; u < N; u++)
            if (b_busy[u] && !b_rd[u] && b_p1[u] == 0 && b_p2[u] == 0) erd[u] = 1'b1;
        check(rd_go == erd, "R5", rd_go, erd);

        elig = '0;
        for (int u = 0; u < N; u++) begin
            war = 1'b0;
            for (int v = 0; v < N; v++)
                if (v != u && b_dst_en[u] && b_busy[v] && !b_rd[v] && b_seq[v] < b_seq[u] &&
                    ((b_s1en[v] && b_s1[v] == b_dst[u]) || (b_s2en[v] && b_s2[v] == b_dst[u])))
                    war = 1'b1;
            if (b_busy[u] && b_rd[u] && cyc >= b_rdc[u] + lat_k(kind_of_u(u)) + 1 && !war)
                elig[u] = 1'b1;
        end
        gu = -1;
        for (int u = 0; u < N; u++)
            if (elig[u] && (gu < 0 || b_seq[u] < b_seq[gu])) gu = u;
        eg  = (gu >= 0) ? (10'd1 << gu) : '0;
        ewr = (gu >= 0 && b_dst_en[gu]) ? eg : '0;
        check(wb_en == eg, "R8", wb_en, eg);
        check(wb_wr == ewr, "R9", wb_wr, ewr);
        if (gu >= 0) check(int'(wb_dst[gu*5 +: 5]) == b_dst[gu], "R8", wb_dst[gu*5 +: 5], b_dst[gu]);
        // R6: every actual grant must not overtake an older unread reader
        for (int u = 0; u < N; u++)
            if (wb_en[u] && b_busy[u] && b_dst_en[u]) begin
                war = 1'b0;
                for (int v = 0; v < N; v++)
                    if (v != u && b_busy[v] && !b_rd[v] && b_seq[v] < b_seq[u] &&
                        ((b_s1en[v] && b_s1[v] == b_dst[u]) || (b_s2en[v] && b_s2[v] == b_dst[u])))
                        war = 1'b1;
                check(!war, "R6", war, 0);
            end

        // issue producers use the table before this cycle's grant clears it
        p1 = '0; p2 = '0;
        if (in_src1_en && pend[in_src1] && pend_u[in_src1] != gu) p1 = 10'd1 << pend_u[in_src1];
        if (in_src2_en && pend[in_src2] && pend_u[in_src2] != gu) p2 = 10'd1 << pend_u[in_src2];
        if (gu >= 0) begin
            if (b_dst_en[gu]) pend[b_dst[gu]] = 1'b0;
            for (int v = 0; v < N; v++) begin
                b_p1[v][gu] = 1'b0;
                b_p2[v][gu] = 1'b0;
            end
            b_busy[gu] = 1'b0;
        end
        for (int u = 0; u < N; u++)
            if (erd[u]) begin b_rd[u] = 1'b1; b_rdc[u] = cyc; end
        if (efire) begin
            k = eu;
            b_busy[k] = 1'b1; b_seq[k] = seqn; seqn++;
            b_dst[k] = in_dst; b_dst_en[k] = dkeep;
            b_s1[k] = in_src1; b_s1en[k] = in_src1_en; b_p1[k] = p1;
            b_s2[k] = in_src2; b_s2en[k] = in_src2_en; b_p2[k] = p2;
            b_rd[k] = 1'b0;
            if (dkeep) begin pend[in_dst] = 1'b1; pend_u[in_dst] = k; end
        end
        last_fire = issue_fire;
        last_wb   = wb_en;
        cyc++;
        @(negedge clk);
    endtask

    task automatic drive(bit v, int t, int d, bit de, int a, bit ae, int b, bit be);
        in_valid = v; in_type = 3'(t); in_dst = 5'(d); in_dst_en = de;
        in_src1 = 5'(a); in_src1_en = ae; in_src2 = 5'(b); in_src2_en = be;
    endtask

    task automatic idle(int n);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n; i++) step();
    endtask

    // R7: unhindered instruction, grant exactly LAT+2 cycles after issue
    task automatic lat_probe(int t, int unit);
        int c0, cw;
        drive(1, t, 1, 1, 0, 0, 0, 0);
        c0 = cyc;
        step();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        cw = -1;
        for (int i = 0; i < 40 && cw < 0; i++) begin
            step();
            if (last_wb[unit]) cw = cyc - 1;
        end
        check(cw - c0 == lat_k(t) + 2, "R7", cw - c0, lat_k(t) + 2);
    endtask

    function automatic int rreg();
        return ($urandom % 3) * 8 + ($urandom % 8);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int u = 0; u < N; u++) begin
            b_busy[u] = 0; b_seq[u] = 0; b_rd[u] = 0; b_p1[u] = 0; b_p2[u] = 0;
            b_dst_en[u] = 0; b_s1en[u] = 0; b_s2en[u] = 0; b_dst[u] = 0; b_s1[u] = 0; b_s2[u] = 0; b_rdc[u] = 0;
        end
        for (int r = 0; r < 32; r++) begin pend[r] = 0; pend_u[r] = 0; end
        repeat (3) @(negedge clk);
        #8;
        check(rd_go == 0 && wb_en == 0 && wb_wr == 0, "R10", {rd_go, wb_en}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        check(issue_stall == 0, "R10", issue_stall, 0);

        // R10: first instruction after reset issues; R7 latencies
        lat_probe(5, 5);
        lat_probe(1, 1);
        lat_probe(0, 0);
        idle(2);

        // R2/R3: three multiplies back to back, third waits for a unit
        drive(1, 6, 2, 1, 0, 0, 0, 0); step();
        drive(1, 6, 3, 1, 0, 0, 0, 0); step();
        drive(1, 6, 4, 1, 0, 0, 0, 0);
        while (!last_fire || in_dst != 5'd4) begin step(); if (last_fire) break; end
        idle(20);

        // R9: zero register as destination twice and as a source
        drive(1, 5, 16, 1, 0, 0, 0, 0); step();
        drive(1, 1, 16, 1, 16, 1, 0, 0); step();
        idle(40);

        // R4/R5/R6: divide feeds a long add whose other source a boolean overwrites
        drive(1, 5, 1, 1, 2, 1, 3, 1); step();
        drive(1, 4, 7, 1, 1, 1, 6, 1); step();
        drive(1, 1, 6, 1, 0, 0, 0, 0); step();
        drive(1, 2, 6, 1, 0, 0, 0, 0);
        for (int i = 0; i < 60 && !last_fire; i++) step();
        idle(40);

        // Random traffic
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6000; i++) begin
            if (!in_valid || last_fire) begin
                int r;
                r = $urandom % 16;
                drive(($urandom % 4) != 0,
                      (r == 15) ? 5 : ((r % 8 == 5) ? 1 : r % 8),
                      rreg(), ($urandom % 8) != 0,
                      rreg(), ($urandom % 3) != 0,
                      rreg(), ($urandom % 2) != 0);
            end
            step();
        end
        idle(60);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule